// File: doc/BRIEF.md
# Radix Translation Context Resolver

This block sits in front of a radix page-table walker. For each accepted `start`, it takes an effective address, a translation-enable flag, the current process and partition identifiers, and the partition table entry. It returns the context the walker needs to begin a lookup.

With translation off, the block clears the four most significant address bits and reports the result as a real address. It makes no memory access in this case.

With translation on, the block uses the two top address bits to pick the identifier pair. The two supervisor-only quadrants fault with a segment fault. For the allowed quadrants, the block checks the selected process ID against the size of the process table. It then fetches that process's table entry over a one-outstanding read port. From the entry it extracts three values:
- the root directory base,
- the root directory size,
- the total tree size.

Each request ends with exactly one single-cycle outcome: completion, segment fault or storage fault. Results stay on the outputs until the next accepted request.

Top module: `rxctx_resolver`

## Requirements
- R1: When `start` is accepted with `xlate_en` low, `done` pulses on the following cycle with `real_mode` = 1 and `eff_addr` equal to `ea` with bits 63:60 forced to zero, and no read request is issued.
- R2: With translation on and `ea[63:62]` = 2'b00, the resolved `ctx_pid` equals `pid_reg` and `ctx_lpid` equals `lpid_reg`.
- R3: With translation on and `ea[63:62]` = 2'b11, `ctx_pid` is zero and `ctx_lpid` equals `lpid_reg`.
- R4: With translation on and `ea[63:62]` equal to 2'b01 or 2'b10, `seg_fault` pulses on the cycle after acceptance and no read request is issued.
- R5: The read request address is `part_entry` with bits 63:60 and 11:0 cleared, plus 16 times the selected PID.
- R6: With S = `part_entry[4:0]`, a selected PID of 2^(S+8) or more raises `stor_fault` on the cycle after acceptance with no read request. A PID just below that limit is fetched normally.
- R7: On completion, `root_base` equals the response word with bits 63:60 and 7:0 cleared, and `root_size` equals response bits 4:0.
- R8: On completion, `tree_size` equals the 5-bit value {response bits 62:61, response bits 7:5} plus 31.
- R9: Every accepted start yields exactly one single-cycle pulse of `done`, `seg_fault` or `stor_fault`. In virtual mode, `done` pulses on the cycle after the response beat.
- R10: A pending read request keeps `rd_req_valid` high and `rd_req_addr` unchanged until `rd_req_ready`, and a `start` that arrives while a request is in flight is ignored.
- R11: Result outputs keep their values while idle, whatever the inputs do, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a resolution (accepted only when idle) |
| ea | input | 64 | Effective address |
| xlate_en | input | 1 | Translation enable; low selects real mode |
| pid_reg | input | PID_W | Current process identifier |
| lpid_reg | input | LPID_W | Current partition identifier |
| part_entry | input | 64 | Partition table entry: process table base 59:12, size code 4:0 |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by memory |
| rd_req_addr | output | 64 | Physical address of the process table entry |
| rd_rsp_valid | input | 1 | Read data beat valid |
| rd_rsp_data | input | 64 | Read data (first doubleword of the entry) |
| done | output | 1 | Resolution completed (one cycle) |
| seg_fault | output | 1 | Supervisor-only quadrant fault (one cycle) |
| stor_fault | output | 1 | Process table bound fault (one cycle) |
| real_mode | output | 1 | Last result was a real-mode address |
| eff_addr | output | 64 | Address with top four bits cleared |
| ctx_pid | output | PID_W | Resolved process identifier |
| ctx_lpid | output | LPID_W | Resolved partition identifier |
| root_base | output | 64 | Radix root directory base |
| root_size | output | 5 | Radix root directory size code |
| tree_size | output | 6 | Total radix tree size |

## Verification
The bench tries the block in four ways.

- **Real mode:** addresses whose top bits are set, including one in a supervisor quadrant. These cases show that masking alone applies and that no quadrant logic or memory access is involved.
- **Quadrant routing:** user and kernel quadrant requests that use different PIDs and partition bases containing junk high bits. These cases separate the PID routing for each quadrant from the address arithmetic.
- **Table bound:** PIDs on both sides of the limit for two size codes. These cases separate an off-by-one error from a shift error.
- **Stalled handshake:** response words at the extremes of the tree-size encoding, combined with a stalled request handshake and a stray start. These cases check the field extraction and the one-outstanding rule.

// File: rtl/rxctx_pkg.sv
package rxctx_pkg;
  localparam int VA_W        = 64;
  localparam int QUAD_HI     = 63;
  localparam int QUAD_LO     = 62;
  localparam int STRIP_BITS  = 4;
  localparam int KEEP_HI     = VA_W - STRIP_BITS - 1;
  localparam int PTB_LO      = 12;
  localparam int RD_LO       = 8;
  localparam int SZ_W        = 5;
  localparam int TS_W        = 6;
  localparam int TS_BIAS     = 31;
  localparam int ENT_SHIFT   = 4;
  localparam int MIN_ENT_LOG = PTB_LO - ENT_SHIFT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    QD_USER = 2'd0,
    QD_HVA  = 2'd1,
    QD_HVB  = 2'd2,
    QD_KERN = 2'd3
  } rx_quad_e;
endpackage

// File: rtl/rxctx_quad_decode.sv
module rxctx_quad_decode
  import rxctx_pkg::*;
#(
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input  logic [VA_W-1:0]   ea,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [LPID_W-1:0] lpid_reg,
  output logic [PID_W-1:0]  sel_pid,
  output logic [LPID_W-1:0] sel_lpid,
  output logic              hv_quad,
  output logic [VA_W-1:0]   stripped
);
  rx_quad_e quad;

  assign quad     = rx_quad_e'(ea[QUAD_HI:QUAD_LO]);
  assign stripped = {{STRIP_BITS{1'b0}}, ea[KEEP_HI:0]};

  always_comb begin
    sel_lpid = lpid_reg;
    sel_pid  = '0;
    hv_quad  = 1'b0;
    unique case (quad)
      QD_USER: sel_pid = pid_reg;
      QD_KERN: sel_pid = '0;
      default: hv_quad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rxctx_ptab_index.sv
module rxctx_ptab_index
  import rxctx_pkg::*;
#(
  parameter int PID_W = 20
) (
  input  logic [VA_W-1:0]  part_entry,
  input  logic [PID_W-1:0] pid,
  output logic [VA_W-1:0]  entry_addr,
  output logic             in_range
);
  localparam int SHW = SZ_W + 2;

  logic [VA_W-1:0] tbl_base;
  logic [VA_W-1:0] pid_ext;
  logic [SHW-1:0]  lim_log;

  assign tbl_base   = {{STRIP_BITS{1'b0}}, part_entry[KEEP_HI:PTB_LO], {PTB_LO{1'b0}}};
  assign pid_ext    = VA_W'(pid);
  assign lim_log    = SHW'(part_entry[SZ_W-1:0]) + SHW'(MIN_ENT_LOG);
  assign in_range   = ((pid_ext >> lim_log) == '0);
  assign entry_addr = tbl_base + (pid_ext << ENT_SHIFT);
endmodule

// File: rtl/rxctx_entry_fields.sv
module rxctx_entry_fields
  import rxctx_pkg::*;
(
  input  logic [VA_W-1:0] entry,
  output logic [VA_W-1:0] root_base,
  output logic [SZ_W-1:0] root_size,
  output logic [TS_W-1:0] tree_size
);
  logic [SZ_W-1:0] ts_code;

  assign ts_code   = {entry[62:61], entry[7:5]};
  assign root_base = {{STRIP_BITS{1'b0}}, entry[KEEP_HI:RD_LO], {RD_LO{1'b0}}};
  assign root_size = entry[SZ_W-1:0];
  assign tree_size = TS_W'(ts_code) + TS_W'(TS_BIAS);
endmodule

// File: rtl/rxctx_resolver.sv
module rxctx_resolver
  import rxctx_pkg::*;
#(
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       ea,
  input  logic              xlate_en,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [63:0]       part_entry,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [63:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  output logic              done,
  output logic              seg_fault,
  output logic              stor_fault,
  output logic              real_mode,
  output logic [63:0]       eff_addr,
  output logic [PID_W-1:0]  ctx_pid,
  output logic [LPID_W-1:0] ctx_lpid,
  output logic [63:0]       root_base,
  output logic [4:0]        root_size,
  output logic [5:0]        tree_size
);
  rx_state_e state_q, state_d;

  logic [PID_W-1:0]  q_pid;
  logic [LPID_W-1:0] q_lpid;
  logic              q_hv;
  logic [VA_W-1:0]   q_strip;
  logic [VA_W-1:0]   ix_addr;
  logic              ix_ok;
  logic [VA_W-1:0]   f_base;
  logic [SZ_W-1:0]   f_rsize;
  logic [TS_W-1:0]   f_tsize;

  logic              accept;
  logic              addr_en, ctx_en, fld_en;
  logic              done_d, seg_d, stor_d, rm_d;

  rxctx_quad_decode #(.PID_W(PID_W), .LPID_W(LPID_W)) u_quad (
    .ea       (ea),
    .pid_reg  (pid_reg),
    .lpid_reg (lpid_reg),
    .sel_pid  (q_pid),
    .sel_lpid (q_lpid),
    .hv_quad  (q_hv),
    .stripped (q_strip)
  );

  rxctx_ptab_index #(.PID_W(PID_W)) u_idx (
    .part_entry (part_entry),
    .pid        (q_pid),
    .entry_addr (ix_addr),
    .in_range   (ix_ok)
  );

  rxctx_entry_fields u_fld (
    .entry     (rd_rsp_data),
    .root_base (f_base),
    .root_size (f_rsize),
    .tree_size (f_tsize)
  );

  assign accept = start && (state_q == ST_IDLE);

  // next-state and enable decode
  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    ctx_en  = 1'b0;
    fld_en  = 1'b0;
    done_d  = 1'b0;
    seg_d   = 1'b0;
    stor_d  = 1'b0;
    rm_d    = real_mode;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          rm_d = !xlate_en;
          if (!xlate_en) begin
            done_d = 1'b1;
          end else if (q_hv) begin
            seg_d = 1'b1;
          end else begin
            ctx_en = 1'b1;
            if (!ix_ok) begin
              stor_d = 1'b1;
            end else begin
              addr_en = 1'b1;
              state_d = ST_REQ;
            end
          end
        end
      end
      ST_REQ: begin
        if (rd_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_rsp_valid) begin
          fld_en  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done       <= 1'b0;
      seg_fault  <= 1'b0;
      stor_fault <= 1'b0;
      real_mode  <= 1'b0;
    end else begin
      state_q    <= state_d;
      done       <= done_d;
      seg_fault  <= seg_d;
      stor_fault <= stor_d;
      real_mode  <= rm_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_addr    <= '0;
      rd_req_addr <= '0;
      ctx_pid     <= '0;
      ctx_lpid    <= '0;
      root_base   <= '0;
      root_size   <= '0;
      tree_size   <= '0;
    end else begin
      if (accept) eff_addr <= q_strip;
      if (addr_en) rd_req_addr <= ix_addr;
      if (ctx_en) begin
        ctx_pid  <= q_pid;
        ctx_lpid <= q_lpid;
      end
      if (fld_en) begin
        root_base <= f_base;
        root_size <= f_rsize;
        tree_size <= f_tsize;
      end
    end
  end

  assign rd_req_valid = (state_q == ST_REQ);

  AST_REAL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_IDLE && !xlate_en) |=> (done && real_mode && !rd_req_valid)); // R1
  AST_HV_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_IDLE && xlate_en && (ea[63:62] == 2'b01 || ea[63:62] == 2'b10))
      |=> (seg_fault && !rd_req_valid)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, seg_fault, stor_fault}) <= 1); // R9
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && rd_rsp_valid) |=> done); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> ($stable(eff_addr) && $stable(root_base) && $stable(tree_size))); // R11
endmodule

// File: tb/sim_rxctx_resolver.sv
`timescale 1ns/1ps
module sim_rxctx_resolver;
  localparam int PW = 20;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [63:0]   ea;
  logic          xlate_en;
  logic [PW-1:0] pid_reg;
  logic [LW-1:0] lpid_reg;
  logic [63:0]   part_entry;
  logic          rd_req_valid;
  logic          rd_req_ready;
  logic [63:0]   rd_req_addr;
  logic          rd_rsp_valid;
  logic [63:0]   rd_rsp_data;
  logic          done, seg_fault, stor_fault, real_mode;
  logic [63:0]   eff_addr, root_base;
  logic [PW-1:0] ctx_pid;
  logic [LW-1:0] ctx_lpid;
  logic [4:0]    root_size;
  logic [5:0]    tree_size;

  always #2.5 clk = ~clk;

  rxctx_resolver #(.PID_W(PW), .LPID_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .xlate_en(xlate_en),
    .pid_reg(pid_reg), .lpid_reg(lpid_reg), .part_entry(part_entry),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .done(done), .seg_fault(seg_fault), .stor_fault(stor_fault), .real_mode(real_mode),
    .eff_addr(eff_addr), .ctx_pid(ctx_pid), .ctx_lpid(ctx_lpid),
    .root_base(root_base), .root_size(root_size), .tree_size(tree_size)
  );

  typedef struct {
    int          kind;   // 0 done, 1 segment, 2 storage
    logic        rm;
    logic [63:0] eff;
    logic [63:0] pid;
    logic [63:0] lpid;
    logic [63:0] base;
    logic [63:0] rsz;
    logic [63:0] tsz;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] addr_q[$];
  logic [63:0] data_q[$];
  exp_t        last_e;
  int n_run = 0, n_fail = 0, n_expect = 0, n_seen = 0, n_extra = 0;
  int g_stall = 0, g_lat = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard as outcomes appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && (done || seg_fault || stor_fault)) begin
        chk("R9 single outcome", 64'($countones({done, seg_fault, stor_fault})), 64'd1);
        if (exp_q.size() == 0) begin
          n_extra++;
          n_fail++;
          $display("FAIL R10 unexpected outcome actual=%b%b%b expected=none", done, seg_fault, stor_fault);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          last_e = e;
          chk("R9 outcome kind", {61'd0, stor_fault, seg_fault, done}, 64'(1 << e.kind));
          if (e.kind == 0) begin
            chk("R1 real_mode", 64'(real_mode), 64'(e.rm));
            chk("R1 eff_addr", eff_addr, e.eff);
            if (!e.rm) begin
              chk("R2/R3 ctx_pid", 64'(ctx_pid), e.pid);
              chk("R2/R3 ctx_lpid", 64'(ctx_lpid), e.lpid);
              chk("R7 root_base", root_base, e.base);
              chk("R7 root_size", 64'(root_size), e.rsz);
              chk("R8 tree_size", 64'(tree_size), e.tsz);
            end
          end
          n_seen++;
        end
      end
    end
  end

  // memory responder
  initial begin
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (rst_n === 1'b1 && rd_req_valid === 1'b1) begin
        logic [63:0] first_addr;
        first_addr = rd_req_addr;
        repeat (g_stall) @(negedge clk);
        if (addr_q.size() == 0) begin
          n_run++;
          n_fail++;
          $display("FAIL R4/R6 unexpected read actual=%h expected=none", rd_req_addr);
        end else begin
          logic [63:0] ea_x;
          ea_x = addr_q.pop_front();
          chk("R5 request address", rd_req_addr, ea_x);
          if (g_stall > 0) begin
            chk("R10 valid held", 64'(rd_req_valid), 64'd1);
            chk("R10 addr stable", rd_req_addr, first_addr);
          end
        end
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        repeat (g_lat) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = (data_q.size() != 0) ? data_q.pop_front() : 64'd0;
      end
    end
  end

  task automatic run(input logic [63:0] a, input logic en, input logic [PW-1:0] p,
                     input logic [LW-1:0] l, input logic [63:0] pt, input logic [63:0] rsp,
                     input int stall, input int lat, input bit spur);
    exp_t e;
    logic [63:0] spid, lim;
    e.rm   = !en;
    e.eff  = a & 64'h0FFF_FFFF_FFFF_FFFF;
    e.lpid = 64'(l);
    spid   = (a[63:62] == 2'b11) ? 64'd0 : 64'(p);
    e.pid  = spid;
    lim    = 64'd1 << (pt[4:0] + 8);
    e.base = rsp & 64'h0FFF_FFFF_FFFF_FF00;
    e.rsz  = 64'(rsp[4:0]);
    e.tsz  = 64'({rsp[62:61], rsp[7:5]}) + 64'd31;
    if (!en) e.kind = 0;
    else if (a[63:62] == 2'b01 || a[63:62] == 2'b10) e.kind = 1;
    else if (spid >= lim) e.kind = 2;
    else begin
      e.kind = 0;
      addr_q.push_back((pt & 64'h0FFF_FFFF_FFFF_F000) + spid * 64'd16);
      data_q.push_back(rsp);
    end
    exp_q.push_back(e);
    n_expect++;
    g_stall = stall;
    g_lat   = lat;
    @(negedge clk);
    ea = a; xlate_en = en; pid_reg = p; lpid_reg = l; part_entry = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (spur) begin
      @(negedge clk);
      ea = 64'h1234; xlate_en = 1'b0; start = 1'b1;  // arrives while request pending
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_seen == n_expect);
    ea = ~a; pid_reg = ~p; lpid_reg = ~l; part_entry = ~pt; xlate_en = !en;
    repeat (4) @(negedge clk);
    chk("R10 no extra outcome", 64'(n_extra), 64'd0);
    chk("R11 eff_addr held", eff_addr, last_e.eff);
    chk("R11 real_mode held", 64'(real_mode), 64'(last_e.rm));
    if (last_e.kind == 0 && !last_e.rm) begin
      chk("R11 root_base held", root_base, last_e.base);
      chk("R11 tree_size held", 64'(tree_size), last_e.tsz);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ea = '0; xlate_en = 1'b0;
    pid_reg = '0; lpid_reg = '0; part_entry = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset done", 64'(done), 64'd0);
    chk("R9 reset faults", 64'({seg_fault, stor_fault}), 64'd0);
    chk("R10 reset req", 64'(rd_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 real mode, including an address in a supervisor quadrant
    run(64'hFEDC_BA98_7654_3210, 1'b0, 20'h5, 12'h3, 64'h0, 64'h0, 0, 0, 0);
    run(64'h4000_0000_0000_1FFF, 1'b0, 20'h5, 12'h3, 64'h0, 64'h0, 0, 0, 0);
    // R2 user quadrant, junk in partition entry high and low bits
    run(64'h0000_1234_5678_9000, 1'b1, 20'h5, 12'h3, 64'hF000_0001_2345_6FE0,
        64'hE000_0000_0ABC_D3E5, 0, 0, 0);
    // R3 kernel quadrant forces PID 0
    run(64'hC000_0000_0000_4000, 1'b1, 20'h4D, 12'h7A, 64'h0000_0000_0010_0003,
        64'h0F00_0000_8000_0011, 0, 2, 0);
    // R4 supervisor quadrants
    run(64'h4000_0000_0000_0000, 1'b1, 20'h1, 12'h1, 64'h0000_0000_0010_0000, 64'h0, 0, 0, 0);
    run(64'h8000_0000_0000_0000, 1'b1, 20'h1, 12'h1, 64'h0000_0000_0010_0000, 64'h0, 0, 0, 0);
    // R6 bound edges, size code 0 (256 entries) and 3 (2048 entries)
    run(64'h0, 1'b1, 20'd255,  12'h2, 64'h0000_0000_0020_0000, 64'h0000_0000_0000_0000, 0, 0, 0);
    run(64'h0, 1'b1, 20'd256,  12'h2, 64'h0000_0000_0020_0000, 64'h0, 0, 0, 0);
    run(64'h0, 1'b1, 20'd2047, 12'h2, 64'h0000_0000_0040_0003, 64'h6000_0000_0000_00E0, 0, 1, 0);
    run(64'h0, 1'b1, 20'd2048, 12'h2, 64'h0000_0000_0040_0003, 64'h0, 0, 0, 0);
    // R10 stalled handshake with a stray start, R8 max tree size
    run(64'h0000_0000_0000_8000, 1'b1, 20'h9, 12'h44, 64'h0000_0000_0080_0001,
        64'h7FFF_FFFF_FFFF_FFFF, 5, 3, 1);
    // R7/R8 minimum tree size
    run(64'h0000_0000_0000_0010, 1'b1, 20'h1F, 12'hFFF, 64'h0000_0000_00A0_0002,
        64'h8000_0000_0000_001F, 1, 0, 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule